// File: doc/BRIEF.md
# Packed SIMD Add-Subtract Unit

This block adds or subtracts two 32-bit source words lane by lane and returns a 32-bit result in the same cycle. A 4-bit opcode chooses the lane format and the arithmetic flavour. Two unsigned 16-bit lanes can either wrap or clamp at their limits. The halving flavours work on four unsigned bytes, two signed halfwords or one signed word. Each of them computes the sum or difference with spare headroom and then shifts it right by one place, with an optional round-up, so a lane can never overflow.

A single sticky overflow bit is kept in a register beside the datapath. It is set whenever an unsigned halfword lane leaves its range on an operation marked valid. It stays set until a clear request or a reset. The combinational result and the overflow seen in the current cycle are also brought out, so a pipeline stage can register them as it needs.

Top module: `simd_addsub`

## Requirements
- R1: Opcode bit 0 selects subtract (1) or add (0). Bits 3:1 select the variant: 0 unsigned halfword wrapping, 1 unsigned halfword clamping, 2 byte halving, 3 byte halving with round-up, 4 signed halfword halving, 5 the same with round-up, 6 word halving, 7 the same with round-up.
- R2: In the unsigned halfword variants, the lanes are bits 15:0 and bits 31:16 and are independent. The wrapping variant returns the low 16 bits of each lane's sum or difference.
- R3: An unsigned halfword add whose true sum exceeds 0xFFFF raises `ovf_now`. In the clamping variant that lane returns 0xFFFF.
- R4: An unsigned halfword subtract whose first lane is smaller than the second raises `ovf_now`. The clamping variant returns 0x0000 for that lane, and the wrapping variant returns the low 16 bits.
- R5: Byte halving treats each of the four bytes as unsigned. It forms the full-precision sum or difference, adds 1 when round-up is selected, shifts right by one place and keeps the low 8 bits.
- R6: Signed halfword halving sign-extends each lane, adds or subtracts, optionally adds 1, shifts arithmetically right by one place and keeps 16 bits.
- R7: Word halving forms the signed sum or difference at 33 or more bits, optionally adds 1, shifts arithmetically right by one place and returns the low 32 bits.
- R8: The halving variants never raise `ovf_now` and never set `ovf_sticky`.
- R9: `ovf_sticky` becomes 1 on the clock edge after a cycle with `op_valid` high and `ovf_now` high. It then stays 1 until cleared. When `op_valid` is low, an overflow has no effect on it.
- R10: `flag_clr` clears `ovf_sticky` on the next edge. When a clear and a valid overflow arrive in the same cycle, the set wins.
- R11: A synchronous active-high `rst` clears `ovf_sticky`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | The current operation may update the sticky flag |
| op_code | input | 4 | Operation select (see R1) |
| src_a | input | 32 | First source word |
| src_b | input | 32 | Second source word (subtrahend) |
| flag_clr | input | 1 | Clear request for the sticky flag |
| result | output | 32 | Lane-wise result, combinational |
| ovf_now | output | 1 | Overflow in the current operation, combinational |
| ovf_sticky | output | 1 | Registered sticky overflow flag |

## Verification
The only state is the sticky bit, and a wrong value of it shows up on `ovf_sticky` one edge after the cycle that caused it. That covers a lost set, a clear that misses, a set that comes from a halving opcode, and a set with `op_valid` low. Datapath errors cannot hide in state: a wrong carry, sign extension, rounding bit or lane placement shows on `result` in the same cycle. The bench therefore checks every opcode against values computed on its own. It uses operands chosen at the lane limits (0x0000, 0xFFFF, 0x8000, 0x7FFFFFFF), where a missing extension bit or a lane crossing would change the answer.

// File: rtl/simd_as_pkg.sv
package simd_as_pkg;

    typedef enum logic [1:0] {
        LK_UH = 2'd0,   // unsigned halfword, wrap or clamp
        LK_UB = 2'd1,   // unsigned byte halving
        LK_SH = 2'd2,   // signed halfword halving
        LK_SW = 2'd3    // signed word halving
    } lane_kind_e;

    typedef struct packed {
        lane_kind_e kind;
        logic       sub;
        logic       rnd;
        logic       sat;
    } as_ctl_t;

    // bit 0: subtract; bits 3:1: variant
    function automatic as_ctl_t as_decode(input logic [3:0] code);
        as_ctl_t c;
        c.sub  = code[0];
        c.rnd  = 1'b0;
        c.sat  = 1'b0;
        c.kind = LK_UH;
        unique case (code[3:1])
            3'd0: c.kind = LK_UH;
            3'd1: begin c.kind = LK_UH; c.sat = 1'b1; end
            3'd2: c.kind = LK_UB;
            3'd3: begin c.kind = LK_UB; c.rnd = 1'b1; end
            3'd4: c.kind = LK_SH;
            3'd5: begin c.kind = LK_SH; c.rnd = 1'b1; end
            3'd6: c.kind = LK_SW;
            default: begin c.kind = LK_SW; c.rnd = 1'b1; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/simd_as_lane.sv
module simd_as_lane #(
    parameter int   W      = 16,
    parameter logic SIGNED = 1'b0
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         halve,
    input  logic         rnd,
    input  logic         sat,
    output logic [W-1:0] res,
    output logic         ovf
);
    localparam int EW = W + 2;

    logic [EW-1:0] ext_a, ext_b, raw, rounded;
    logic          lane_unused;

    always_comb begin
        ext_a   = SIGNED ? {{2{a[W-1]}}, a} : {2'b00, a};
        ext_b   = SIGNED ? {{2{b[W-1]}}, b} : {2'b00, b};
        raw     = sub ? (ext_a - ext_b) : (ext_a + ext_b);
        rounded = raw + {{(EW-1){1'b0}}, rnd};
        // carry out of the lane on add, negative result on subtract
        ovf     = !halve && (sub ? raw[EW-1] : raw[W]);
        if (halve)
            res = rounded[W:1];
        else if (sat && ovf)
            res = sub ? '0 : '1;
        else
            res = raw[W-1:0];
    end

    assign lane_unused = ^{rounded[EW-1], rounded[0], raw[EW-2]};

    always_comb begin
        if (!halve && sat && ovf && !sub)
            a_r3_clamp_high: assert (res == {W{1'b1}});
        if (!halve && sat && ovf && sub)
            a_r4_clamp_low: assert (res == {W{1'b0}});
    end

endmodule

// File: rtl/simd_as_core.sv
module simd_as_core
    import simd_as_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] result,
    output logic              ovf
);
    localparam int N16 = DATA_W / 16;
    localparam int N8  = DATA_W / 8;

    as_ctl_t ctl;
    assign ctl = as_decode(op_code);

    logic [DATA_W-1:0] uh_res, ub_res, sh_res, sw_res;
    logic [N16-1:0]    uh_ovf;
    logic [N8-1:0]     ub_ovf_unused;
    logic [N16-1:0]    sh_ovf_unused;
    logic              sw_ovf_unused;

    for (genvar g = 0; g < N16; g++) begin : g_uh
        simd_as_lane #(.W(16), .SIGNED(1'b0)) u_lane (
            .a(src_a[16*g +: 16]), .b(src_b[16*g +: 16]),
            .sub(ctl.sub), .halve(1'b0), .rnd(1'b0), .sat(ctl.sat),
            .res(uh_res[16*g +: 16]), .ovf(uh_ovf[g])
        );
    end

    for (genvar g = 0; g < N8; g++) begin : g_ub
        simd_as_lane #(.W(8), .SIGNED(1'b0)) u_lane (
            .a(src_a[8*g +: 8]), .b(src_b[8*g +: 8]),
            .sub(ctl.sub), .halve(1'b1), .rnd(ctl.rnd), .sat(1'b0),
            .res(ub_res[8*g +: 8]), .ovf(ub_ovf_unused[g])
        );
    end

    for (genvar g = 0; g < N16; g++) begin : g_sh
        simd_as_lane #(.W(16), .SIGNED(1'b1)) u_lane (
            .a(src_a[16*g +: 16]), .b(src_b[16*g +: 16]),
            .sub(ctl.sub), .halve(1'b1), .rnd(ctl.rnd), .sat(1'b0),
            .res(sh_res[16*g +: 16]), .ovf(sh_ovf_unused[g])
        );
    end

    simd_as_lane #(.W(DATA_W), .SIGNED(1'b1)) u_sw (
        .a(src_a), .b(src_b),
        .sub(ctl.sub), .halve(1'b1), .rnd(ctl.rnd), .sat(1'b0),
        .res(sw_res), .ovf(sw_ovf_unused)
    );

    always_comb begin
        unique case (ctl.kind)
            LK_UH:   result = uh_res;
            LK_UB:   result = ub_res;
            LK_SH:   result = sh_res;
            default: result = sw_res;
        endcase
        ovf = (ctl.kind == LK_UH) && (|uh_ovf);
    end

endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
    import simd_as_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [3:0]  op_code,
    input  logic [31:0] src_a,
    input  logic [31:0] src_b,
    input  logic        flag_clr,
    output logic [31:0] result,
    output logic        ovf_now,
    output logic        ovf_sticky
);
    simd_as_core #(.DATA_W(32)) u_core (
        .op_code(op_code),
        .src_a(src_a),
        .src_b(src_b),
        .result(result),
        .ovf(ovf_now)
    );

    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else
            flag_q <= (flag_q & ~flag_clr) | (op_valid & ovf_now);
    end

    assign ovf_sticky = flag_q;

    a_r8_halving_quiet: assert property (@(posedge clk) disable iff (rst)
        (op_code[3:1] >= 3'd2) |-> !ovf_now);

    a_r8_halving_no_set: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code[3:1] >= 3'd2 && !ovf_sticky && !flag_clr) |=> !ovf_sticky);

    a_r9_set_on_overflow: assert property (@(posedge clk) disable iff (rst)
        (op_valid && ovf_now) |=> ovf_sticky);

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (ovf_sticky && !flag_clr) |=> ovf_sticky);

    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !(op_valid && ovf_now)) |=> !ovf_sticky);

    a_r11_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !ovf_sticky);

endmodule

// File: tb/test_simd_addsub.sv
`timescale 1ns/1ps
module test_simd_addsub;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [3:0]  op_code;
    logic [31:0] src_a, src_b;
    logic        flag_clr;
    logic [31:0] result;
    logic        ovf_now, ovf_sticky;

    int n_checks = 0;
    int n_fail   = 0;
    logic model_flag = 1'b0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    simd_addsub i_simd_addsub (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .src_a(src_a), .src_b(src_b), .flag_clr(flag_clr),
        .result(result), .ovf_now(ovf_now), .ovf_sticky(ovf_sticky)
    );

    // independent reference, written from the requirements
    function automatic logic [31:0] ref_calc(input logic [3:0] op, input logic [31:0] a,
                                             input logic [31:0] b, output logic ov);
        logic [31:0] r;
        logic        sub;
        int          x, y, s;
        longint      lx, ly, ls;
        r   = '0;
        ov  = 1'b0;
        sub = op[0];
        case (op[3:1])
            3'd0, 3'd1: for (int l = 0; l < 2; l++) begin
                x = int'(a[16*l +: 16]);
                y = int'(b[16*l +: 16]);
                s = sub ? x - y : x + y;
                if (sub ? (x < y) : (s > 65535)) begin
                    ov = 1'b1;
                    if (op[3:1] == 3'd1) s = sub ? 0 : 65535;
                end
                r[16*l +: 16] = s[15:0];
            end
            3'd2, 3'd3: for (int l = 0; l < 4; l++) begin
                x = int'(a[8*l +: 8]);
                y = int'(b[8*l +: 8]);
                s = (sub ? x - y : x + y) + int'(op[1]);
                s = s >>> 1;
                r[8*l +: 8] = s[7:0];
            end
            3'd4, 3'd5: for (int l = 0; l < 2; l++) begin
                x = int'($signed(a[16*l +: 16]));
                y = int'($signed(b[16*l +: 16]));
                s = (sub ? x - y : x + y) + int'(op[1]);
                s = s >>> 1;
                r[16*l +: 16] = s[15:0];
            end
            default: begin
                lx = longint'($signed(a));
                ly = longint'($signed(b));
                ls = (sub ? lx - ly : lx + ly) + longint'(op[1]);
                ls = ls >>> 1;
                r  = ls[31:0];
            end
        endcase
        return r;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // drive at a falling edge, check combinational outputs, then the flag after the edge
    task automatic apply(input string req, input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic vld, input logic clr);
        logic [31:0] exp_r;
        logic        exp_o;
        op_code = op; src_a = a; src_b = b; op_valid = vld; flag_clr = clr;
        exp_r = ref_calc(op, a, b, exp_o);
        #1;
        check(req, $sformatf("result op=%h", op), result, exp_r);
        check(req, $sformatf("ovf_now op=%h", op), {31'b0, ovf_now}, {31'b0, exp_o});
        model_flag = (model_flag & ~clr) | (vld & exp_o);
        @(negedge clk);
        check(req, "ovf_sticky", {31'b0, ovf_sticky}, {31'b0, model_flag});
    endtask

    task automatic do_reset();
        rst = 1'b1; op_valid = 1'b0; flag_clr = 1'b0;
        op_code = 4'h0; src_a = '0; src_b = '0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        model_flag = 1'b0;
        check("R11", "flag after reset", {31'b0, ovf_sticky}, 32'd0);
    endtask

    task automatic t_uh_wrap();   // R2, R3, R4 wrapping
        apply("R2", 4'h0, 32'h1234_0001, 32'h0001_0002, 1'b1, 1'b0);
        check("R2", "literal lanes", result, 32'h1235_0003);
        apply("R3", 4'h0, 32'hFFFF_0001, 32'h0002_0003, 1'b0, 1'b0);
        apply("R4", 4'h1, 32'h0005_0001, 32'h0003_0002, 1'b0, 1'b0);
    endtask

    task automatic t_uh_clamp();  // R3, R4 clamping
        apply("R3", 4'h2, 32'h8000_FFF0, 32'h8000_0020, 1'b0, 1'b0);
        check("R3", "literal clamp high", result, 32'hFFFF_FFFF);
        apply("R4", 4'h3, 32'h0001_0010, 32'h0002_0008, 1'b0, 1'b0);
        check("R4", "literal clamp low", result, 32'h0000_0008);
        apply("R3", 4'h2, 32'h7FFF_0001, 32'h8000_0001, 1'b0, 1'b0);
    endtask

    task automatic t_bytes();     // R5
        apply("R5", 4'h4, 32'hFF01_8003, 32'hFF02_8001, 1'b1, 1'b0);
        apply("R5", 4'h6, 32'hFF01_8003, 32'hFF02_8001, 1'b1, 1'b0);
        apply("R5", 4'h5, 32'h0010_FF00, 32'h0101_00FF, 1'b1, 1'b0);
        apply("R5", 4'h7, 32'h0010_FF00, 32'h0101_00FF, 1'b1, 1'b0);
        check("R5", "literal round sub", result, 32'h0008_8081);
    endtask

    task automatic t_shalf();     // R6
        apply("R6", 4'h8, 32'h8000_7FFF, 32'h8000_7FFF, 1'b1, 1'b0);
        check("R6", "literal extremes", result, 32'h8000_7FFF);
        apply("R6", 4'h9, 32'h8000_7FFF, 32'h7FFF_8000, 1'b1, 1'b0);
        apply("R6", 4'hA, 32'hFFFF_0001, 32'h0000_0000, 1'b1, 1'b0);
        apply("R6", 4'hB, 32'h0003_FFFF, 32'h0006_0002, 1'b1, 1'b0);
    endtask

    task automatic t_word();      // R7, R8
        apply("R7", 4'hE, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b0);
        check("R7", "literal max round", result, 32'h7FFF_FFFF);
        apply("R7", 4'hD, 32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 1'b0);
        check("R7", "literal min sub", result, 32'h8000_0000);
        apply("R8", 4'hF, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1, 1'b0);
        apply("R8", 4'hC, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0);
        check("R8", "flag untouched by halving", {31'b0, ovf_sticky}, 32'd0);
    endtask

    task automatic t_sticky();    // R9, R10
        apply("R9", 4'h0, 32'h0000_FFFF, 32'h0000_0001, 1'b0, 1'b0);
        check("R9", "no set without valid", {31'b0, ovf_sticky}, 32'd0);
        apply("R9", 4'h1, 32'h0000_0000, 32'h0000_0001, 1'b1, 1'b0);
        apply("R9", 4'h0, 32'h0000_0001, 32'h0000_0001, 1'b1, 1'b0);
        apply("R9", 4'h6, 32'h0102_0304, 32'h0506_0708, 1'b1, 1'b0);
        check("R9", "flag held", {31'b0, ovf_sticky}, 32'd1);
        apply("R10", 4'h0, 32'h0, 32'h0, 1'b0, 1'b1);
        check("R10", "flag cleared", {31'b0, ovf_sticky}, 32'd0);
        apply("R10", 4'h3, 32'h0000_0000, 32'h0001_0000, 1'b1, 1'b1);
        check("R10", "set beats clear", {31'b0, ovf_sticky}, 32'd1);
    endtask

    task automatic t_sweep();     // R1: every opcode with boundary operands
        logic [31:0] pa [4] = '{32'hFFFF_0000, 32'h8000_7FFF, 32'h00FF_FF01, 32'h1357_9BDF};
        logic [31:0] pb [4] = '{32'h0001_FFFF, 32'h8001_8000, 32'hFF01_00FF, 32'hFDB9_7531};
        for (int op = 0; op < 16; op++)
            for (int p = 0; p < 4; p++)
                apply("R1", 4'(op), pa[p], pb[p], 1'b1, 1'b0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        t_uh_wrap();
        t_uh_clamp();
        t_bytes();
        t_shalf();
        t_word();
        t_sticky();
        t_sweep();
        do_reset();
        done = 1'b1;
        finish_run();
    end

endmodule